// File: doc/BRIEF.md
# LIN Slave Frame Header Detector

This block watches the receive-data line of a LIN slave node and recognises the start of a frame. A bit-time tick from an external baud generator marks the middle of each bit. A run of at least eleven low samples counts as a synch break. The block then enters a synch-field state, in which it counts falling edges on the line. With automatic synchronisation enabled, it reports to the baud logic the number of clock cycles between the first and the fifth falling edge of the 0x55 synch byte.

A mode bit selects when a header is reported. In break mode the header flag is raised as soon as the break is recognised. In identifier mode the flag is raised only after a break, a complete synch field and an identifier byte have arrived back to back, with correct parity and a high stop bit. The flag drives an interrupt through an enable bit. Software clears the flag with a two-step sequence: an access to the status register, then a read of the control register. Software can also abandon a synch field in progress by writing the control register with the synch-state bit at 0. If the synch field stalls, a timeout returns the block to idle.

Top module: `lin_hdr_detect`

## Requirements
- R1: Eleven consecutive low samples of the line at bit ticks set the synch-state bit (control register, address 1, bit 3). Ten low samples followed by a high one leave it at 0.
- R2: With the mode bit (control bit 0) at 0, the header flag (status register, address 0, bit 0) is set when a break is recognised.
- R3: With the mode bit at 1, the flag is set only after break, synch field and identifier byte. The identifier byte is sent LSB first with bits [5:0] as the identifier, bit 6 = id0^id1^id2^id4 and bit 7 = NOT(id1^id3^id4^id5). Either parity bit wrong, or a low stop bit, means no flag.
- R4: The flag is cleared only by a read of address 1 when the previous register access was to address 0. Any access to another address in between cancels the clear.
- R5: irq is 1 exactly one cycle after the interrupt-enable bit (control bit 1) and the flag are both 1, and 0 otherwise.
- R6: The synch-state bit returns to 0 at the fifth falling edge after the break. If the auto-sync bit (control bit 2) is 1, meas_valid pulses for one cycle and meas_span carries the number of clock cycles from the first to the fifth edge. If the auto-sync bit is 0, meas_valid stays 0.
- R7: A control write with bit 3 at 0 during the synch-field state returns the block to idle. The rest of that synch field and identifier produce no measurement and no flag.
- R8: If fewer than five falling edges arrive within 14 bit ticks after the break, the synch-state bit returns to 0 with no measurement. In identifier mode no flag is set.
- R9: After reset the flag, irq, meas_valid and all control bits are 0.
- R10: After a header in identifier mode, address 2 reads the six identifier bits in [5:0], with [7:6] at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx | input | 1 | Receive line, already synchronised, low = dominant |
| bit_tick | input | 1 | One-cycle pulse at the middle of each bit time |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 control, 2 identifier |
| reg_wdata | input | 4 | Write data for the control register |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| irq | output | 1 | Header interrupt |
| meas_valid | output | 1 | One-cycle strobe for a new synch-field measurement |
| meas_span | output | 16 | Clock cycles from first to fifth synch-field edge |

## Verification
The bench runs random frames with random mode, auto-sync, interrupt enable, break length and identifier, and corrupts the parity in about a quarter of them. A parity function that is wrong, or one that ignores a parity bit, shows up as a flag that differs from the expected value in identifier mode. A break counter set to ten bits is caught by the case of ten low bits followed by a high bit. An edge counter that stops one edge early or late gives a measured span other than eight bit times.

The bench breaks the clear sequence with a read of the identifier register, and expects the flag to survive. It also aborts a synch field by software and starves another one of edges. A design that ignored the abort or the timeout would report a measurement or raise the flag on the identifier that follows.

// File: rtl/lhd_pkg.sv
package lhd_pkg;

  // register addresses (one decoded register per address)
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_ID   = 2'd2;

  // identifier byte receiver phases
  typedef enum logic [1:0] {
    ID_WSTOP,
    ID_WSTART,
    ID_DATA,
    ID_STOP
  } id_st_t;

  // two protection bits over six identifier bits
  function automatic logic id_parity_ok(input logic [7:0] b);
    logic p0, p1;
    p0 = b[0] ^ b[1] ^ b[2] ^ b[4];
    p1 = ~(b[1] ^ b[3] ^ b[4] ^ b[5]);
    return (b[6] == p0) && (b[7] == p1);
  endfunction

endpackage

// File: rtl/lhd_brk.sv
module lhd_brk #(
  parameter int BRK_BITS = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic rx_s,
  output logic hit
);
  localparam int BCW = $clog2(BRK_BITS + 1);

  logic [BCW-1:0] lowcnt;

  assign hit = en && tick && !rx_s && (lowcnt == BCW'(BRK_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      lowcnt <= '0;
    end else if (!en || hit) begin
      lowcnt <= '0;
    end else if (tick) begin
      lowcnt <= rx_s ? '0 : lowcnt + 1'b1;
    end
  end

  // a break can only complete after BRK_BITS-1 low ticks were already seen
  p_brk_run_r1: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(lowcnt) == BCW'(BRK_BITS - 1) || $past(tick) == 1'b0);

endmodule

// File: rtl/lhd_sync.sv
module lhd_sync #(
  parameter int TMO_BITS = 14,
  parameter int SPAN_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              abort,
  input  logic              fall,
  input  logic              tick,
  output logic              active,
  output logic              done,
  output logic [SPAN_W-1:0] span
);
  localparam int TCW     = $clog2(TMO_BITS + 1);
  localparam int N_EDGES = 5;

  logic [2:0]        ecnt;
  logic [TCW-1:0]    tcnt;
  logic [SPAN_W-1:0] scnt;
  logic              tmo;

  assign done = active && !abort && fall && (ecnt == 3'(N_EDGES - 1));
  assign tmo  = active && !abort && !done && tick && (tcnt == TCW'(TMO_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      ecnt   <= '0;
      tcnt   <= '0;
      scnt   <= '0;
      span   <= '0;
    end else if (start) begin
      active <= 1'b1;
      ecnt   <= '0;
      tcnt   <= '0;
      scnt   <= '0;
    end else if (active) begin
      if (abort || done || tmo) begin
        active <= 1'b0;
        if (done) span <= scnt;
      end else begin
        if (fall) ecnt <= ecnt + 1'b1;
        if (fall && ecnt == 3'd0) scnt <= SPAN_W'(1);
        else if (ecnt != 3'd0 && scnt != '1) scnt <= scnt + 1'b1;
        if (tick) tcnt <= tcnt + 1'b1;
      end
    end
  end

  p_edge_bound_r6: assert property (@(posedge clk) disable iff (rst)
    active |-> ecnt < 3'(N_EDGES));

  // leaving the synch state needs an abort, an edge or a tick
  p_exit_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> $past(abort || fall || tick));

endmodule

// File: rtl/lhd_idrx.sv
module lhd_idrx
  import lhd_pkg::*;
#(
  parameter int TMO_BITS = 14
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       tick,
  input  logic       rx_s,
  output logic       busy,
  output logic       ok,
  output logic [5:0] id
);
  localparam int TCW = $clog2(TMO_BITS + 1);

  id_st_t         st;
  logic [7:0]     shreg;
  logic [2:0]     bcnt;
  logic [TCW-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      st    <= ID_WSTOP;
      shreg <= '0;
      bcnt  <= '0;
      tcnt  <= '0;
      ok    <= 1'b0;
      id    <= '0;
    end else begin
      ok <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        st   <= ID_WSTOP;
        tcnt <= '0;
        bcnt <= '0;
      end else if (busy && tick) begin
        case (st)
          ID_WSTOP, ID_WSTART: begin
            if (tcnt == TCW'(TMO_BITS - 1)) begin
              busy <= 1'b0;
            end else begin
              tcnt <= tcnt + 1'b1;
              if (st == ID_WSTOP && rx_s) st <= ID_WSTART;
              if (st == ID_WSTART && !rx_s) begin
                st   <= ID_DATA;
                bcnt <= '0;
              end
            end
          end
          ID_DATA: begin
            shreg <= {rx_s, shreg[7:1]};
            bcnt  <= bcnt + 1'b1;
            if (bcnt == 3'd7) st <= ID_STOP;
          end
          default: begin
            busy <= 1'b0;
            if (rx_s && id_parity_ok(shreg)) begin
              ok <= 1'b1;
              id <= shreg[5:0];
            end
          end
        endcase
      end
    end
  end

  // an accepted identifier needs a high stop sample at a tick
  p_ok_stop_r3: assert property (@(posedge clk) disable iff (rst)
    ok |-> $past(rx_s && tick && busy));

endmodule

// File: rtl/lhd_regs.sv
module lhd_regs
  import lhd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic       rd,
  input  logic [1:0] addr,
  input  logic [3:0] wdata,
  input  logic       hdr_set,
  input  logic       sync_act,
  input  logic [5:0] id,
  output logic [7:0] rdata,
  output logic       mode,
  output logic       ie,
  output logic       autos,
  output logic       sw_abort,
  output logic       irq
);
  logic flag;
  logic armed;
  logic clr;

  assign sw_abort = wr && (addr == A_CTRL) && !wdata[3];
  assign clr      = rd && (addr == A_CTRL) && armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= 1'b0;
      ie    <= 1'b0;
      autos <= 1'b0;
      flag  <= 1'b0;
      armed <= 1'b0;
      irq   <= 1'b0;
      rdata <= '0;
    end else begin
      if (wr && addr == A_CTRL) {autos, ie, mode} <= wdata[2:0];
      if (wr || rd) armed <= (addr == A_STAT);
      if (hdr_set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      irq <= ie && flag;
      if (rd) begin
        case (addr)
          A_STAT:  rdata <= {7'b0, flag};
          A_CTRL:  rdata <= {4'b0, sync_act, autos, ie, mode};
          A_ID:    rdata <= {2'b0, id};
          default: rdata <= '0;
        endcase
      end
    end
  end

  p_flag_clear_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(rd && addr == A_CTRL && armed));

  p_irq_on_r5: assert property (@(posedge clk) disable iff (rst)
    (ie && flag) |=> irq);

  p_irq_off_r5: assert property (@(posedge clk) disable iff (rst)
    !(ie && flag) |=> !irq);

endmodule

// File: rtl/lin_hdr_detect.sv
module lin_hdr_detect #(
  parameter int BRK_BITS = 11,
  parameter int TMO_BITS = 14,
  parameter int SPAN_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx,
  input  logic              bit_tick,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [3:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq,
  output logic              meas_valid,
  output logic [SPAN_W-1:0] meas_span
);
  logic       rx_s, rx_p, fall;
  logic       mode, ie, autos, sw_abort;
  logic       brk_hit, sync_act, sync_done, id_busy, id_ok;
  logic       hdr_set;
  logic [5:0] id;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_s       <= 1'b1;
      rx_p       <= 1'b1;
      meas_valid <= 1'b0;
    end else begin
      rx_s       <= rx;
      rx_p       <= rx_s;
      meas_valid <= sync_done && autos;
    end
  end

  assign fall    = rx_p && !rx_s;
  assign hdr_set = (brk_hit && !mode) || id_ok;

  lhd_brk #(.BRK_BITS(BRK_BITS)) u_brk (
    .clk(clk), .rst(rst), .en(!sync_act && !id_busy),
    .tick(bit_tick), .rx_s(rx_s), .hit(brk_hit)
  );

  lhd_sync #(.TMO_BITS(TMO_BITS), .SPAN_W(SPAN_W)) u_sync (
    .clk(clk), .rst(rst), .start(brk_hit), .abort(sw_abort),
    .fall(fall), .tick(bit_tick), .active(sync_act),
    .done(sync_done), .span(meas_span)
  );

  lhd_idrx #(.TMO_BITS(TMO_BITS)) u_idrx (
    .clk(clk), .rst(rst), .start(sync_done && mode), .tick(bit_tick),
    .rx_s(rx_s), .busy(id_busy), .ok(id_ok), .id(id)
  );

  lhd_regs u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .hdr_set(hdr_set), .sync_act(sync_act), .id(id),
    .rdata(reg_rdata), .mode(mode), .ie(ie), .autos(autos),
    .sw_abort(sw_abort), .irq(irq)
  );

  p_phase_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(sync_act && id_busy));

  p_meas_auto_r6: assert property (@(posedge clk) disable iff (rst)
    meas_valid |-> $past(autos));

endmodule

// File: tb/sim_lin_hdr_detect.sv
module sim_lin_hdr_detect;
  localparam int BP = 16;

  logic        clk = 1'b0;
  logic        rst, rx, bit_tick, reg_wr, reg_rd;
  logic [1:0]  reg_addr;
  logic [3:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        irq, meas_valid;
  logic [15:0] meas_span;

  int n_chk = 0, n_bad = 0, mv_cnt = 0;
  int mv_last = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lin_hdr_detect u0 (
    .clk(clk), .rst(rst), .rx(rx), .bit_tick(bit_tick),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .meas_valid(meas_valid), .meas_span(meas_span)
  );

  always @(negedge clk) if (meas_valid) begin
    mv_cnt++;
    mv_last = int'(meas_span);
  end

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bit_out(input logic v);
    for (int k = 0; k < BP; k++) begin
      @(negedge clk);
      rx = v;
      bit_tick = (k == BP / 2);
    end
  endtask

  task automatic bits(input logic v, input int n);
    for (int i = 0; i < n; i++) bit_out(v);
  endtask

  task automatic send_byte(input logic [7:0] b);
    bit_out(1'b0);
    for (int i = 0; i < 8; i++) bit_out(b[i]);
    bit_out(1'b1);
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic [7:0] mk_id(input logic [5:0] i, input int bad);
    logic [7:0] b;
    b = {~(i[1] ^ i[3] ^ i[4] ^ i[5]), i[0] ^ i[1] ^ i[2] ^ i[4], i};
    if (bad == 1) b[6] = ~b[6];
    if (bad == 2) b[7] = ~b[7];
    return b;
  endfunction

  // control word: bit3 keep synch state, bit2 auto-sync, bit1 irq enable, bit0 mode
  function automatic logic [3:0] ctl(input logic m, input logic ie, input logic au);
    return {1'b1, au, ie, m};
  endfunction

  task automatic clear_flag();
    logic [7:0] d;
    rd_reg(2'd0, d);
    rd_reg(2'd1, d);
  endtask

  initial begin
    logic [7:0] d;
    int mv0;
    rst = 1'b1; rx = 1'b1; bit_tick = 1'b0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    void'($urandom(32'd7321));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R9 reset state
    chk(int'(irq), 0, "R9 irq after reset");
    chk(int'(meas_valid), 0, "R9 meas_valid after reset");
    rd_reg(2'd1, d); chk(int'(d), 0, "R9 control after reset");
    rd_reg(2'd0, d); chk(int'(d[0]), 0, "R9 flag after reset");

    // R1 ten low bits are not a break
    wr_reg(2'd1, ctl(1'b0, 1'b0, 1'b1));
    bits(1'b0, 10); bits(1'b1, 2);
    rd_reg(2'd1, d); chk(int'(d[3]), 0, "R1 ten lows no synch state");
    rd_reg(2'd0, d); chk(int'(d[0]), 0, "R2 ten lows no flag");

    // R1 + R7 break then software abort, identifier mode
    wr_reg(2'd1, ctl(1'b1, 1'b0, 1'b1));
    mv0 = mv_cnt;
    bits(1'b0, 11);
    rd_reg(2'd1, d); chk(int'(d[3]), 1, "R1 eleven lows set synch state");
    wr_reg(2'd1, 4'b0101);
    rd_reg(2'd1, d); chk(int'(d[3]), 0, "R7 software clear of synch state");
    bits(1'b1, 1); send_byte(8'h55); bits(1'b1, 1);
    send_byte(mk_id(6'h12, 0)); bits(1'b1, 3);
    chk(mv_cnt - mv0, 0, "R7 no measurement after abort");
    rd_reg(2'd0, d); chk(int'(d[0]), 0, "R7 no flag after abort");

    // R8 synch field starved of edges
    wr_reg(2'd1, ctl(1'b1, 1'b0, 1'b1));
    mv0 = mv_cnt;
    bits(1'b0, 11); bits(1'b1, 1);
    bit_out(0); bit_out(1); bit_out(0); bit_out(1); bit_out(0);
    bits(1'b1, 16);
    rd_reg(2'd1, d); chk(int'(d[3]), 0, "R8 timeout leaves synch state");
    chk(mv_cnt - mv0, 0, "R8 no measurement on timeout");
    send_byte(mk_id(6'h2A, 0)); bits(1'b1, 3);
    rd_reg(2'd0, d); chk(int'(d[0]), 0, "R8 no flag after timeout");

    // R4 + R5 clear sequence and interrupt, break mode
    wr_reg(2'd1, ctl(1'b0, 1'b1, 1'b0));
    bits(1'b0, 11); bits(1'b1, 16);
    chk(int'(irq), 1, "R5 irq with enable and flag");
    wr_reg(2'd1, ctl(1'b0, 1'b1, 1'b0));
    rd_reg(2'd1, d);
    rd_reg(2'd0, d); chk(int'(d[0]), 1, "R4 control read alone keeps flag");
    rd_reg(2'd2, d);
    rd_reg(2'd1, d);
    rd_reg(2'd0, d); chk(int'(d[0]), 1, "R4 intervening access cancels clear");
    rd_reg(2'd1, d);
    rd_reg(2'd0, d); chk(int'(d[0]), 0, "R4 sequence clears flag");
    chk(int'(irq), 0, "R5 irq low after clear");

    // R5 enable gates interrupt
    wr_reg(2'd1, ctl(1'b0, 1'b0, 1'b0));
    bits(1'b0, 12); bits(1'b1, 16);
    chk(int'(irq), 0, "R5 irq inhibited when disabled");
    wr_reg(2'd1, ctl(1'b0, 1'b1, 1'b0));
    @(negedge clk);
    chk(int'(irq), 1, "R5 irq after enabling");
    clear_flag();

    // random frames
    for (int it = 0; it < 24; it++) begin
      logic m, ie, au;
      logic [5:0] idv;
      int bad, blen, fexp;
      m = 1'($urandom % 2); ie = 1'($urandom % 2); au = 1'($urandom % 2);
      idv = 6'($urandom % 64);
      bad = (($urandom % 4) == 0) ? 1 + int'($urandom % 2) : 0;
      if (it == 0) begin m = 1; bad = 2; end
      if (it == 1) begin m = 1; bad = 0; au = 1; end
      blen = 11 + int'($urandom % 3);
      fexp = (!m || bad == 0) ? 1 : 0;
      wr_reg(2'd1, ctl(m, ie, au));
      mv0 = mv_cnt;
      bits(1'b0, blen); bits(1'b1, 1);
      send_byte(8'h55); bits(1'b1, 1 + int'($urandom % 2));
      send_byte(mk_id(idv, bad)); bits(1'b1, 3);
      rd_reg(2'd1, d); chk(int'(d[3]), 0, "R6 synch state ends after field");
      chk(mv_cnt - mv0, au ? 1 : 0, "R6 measurement strobe count");
      if (au) chk(mv_last, 8 * BP, "R6 measured span");
      if (m && fexp == 1) begin
        rd_reg(2'd2, d); chk(int'(d), int'(idv), "R10 identifier readback");
      end
      rd_reg(2'd0, d);
      chk(int'(d[0]), fexp, m ? "R3 identifier mode flag" : "R2 break mode flag");
      chk(int'(irq), int'(ie) & fexp, "R5 irq follows enable and flag");
      rd_reg(2'd1, d);
      rd_reg(2'd0, d); chk(int'(d[0]), 0, "R4 flag cleared after frame");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule